// File: doc/BRIEF.md
# ASCII Hexadecimal Character Codec

This block converts between printable hexadecimal characters and their numeric values. In one mode it takes a single ASCII byte and yields the 4-bit value it stands for, raising an error flag when the byte is not a hexadecimal digit. Digits and both letter cases are accepted. In the other mode it takes a full byte and produces the two uppercase ASCII characters that spell it, packed into one 16-bit word.

A producer offers a byte and a mode on a valid/ready handshake. The block registers the result, so it appears one clock after the byte is accepted, marked by a one-cycle output valid strobe. Between accepted inputs the registered results hold their values. The block is meant to sit beside a character stream, such as a debug console or a sensor link, where it replaces a short software sequence of compares and adds.

Top module: `hex_char_codec`

## Requirements
- R1: While rst_n is low, in_ready and out_valid are 0 and out_nibble, out_err and out_word are 0.
- R2: In decode mode (in_mode = 0), bytes 0x30 to 0x39 give out_nibble 0 to 9 with out_err = 0.
- R3: In decode mode, bytes 0x41 to 0x46 (uppercase A to F) give out_nibble 10 to 15 with out_err = 0.
- R4: In decode mode, bytes 0x61 to 0x66 (lowercase a to f) give out_nibble 10 to 15 with out_err = 0.
- R5: In decode mode, every other byte value gives out_err = 1 and out_nibble = 0.
- R6: In encode mode (in_mode = 1), a nibble value 0 to 9 becomes character 0x30 to 0x39 and a value 10 to 15 becomes 0x41 to 0x46; lowercase letters are never produced.
- R7: In encode mode, the character for in_byte[7:4] sits in out_word[15:8] and the character for in_byte[3:0] sits in out_word[7:0].
- R8: out_valid is 1 in exactly the cycle after an edge where in_valid and in_ready were both 1, and the results of that input are on the outputs in that cycle.
- R9: A decode result drives out_word to 0; an encode result drives out_nibble and out_err to 0.
- R10: in_ready is 1 from the first clock edge after reset release onward, and when no input is accepted the result outputs keep their values regardless of in_byte and in_mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Block can take a byte |
| in_mode | input | 1 | 0 = decode character, 1 = encode byte |
| in_byte | input | 8 | Character to decode or byte to encode |
| out_valid | output | 1 | One-cycle strobe: new result present |
| out_nibble | output | 4 | Decoded value |
| out_err | output | 1 | Decoded byte was not a hexadecimal digit |
| out_word | output | 16 | Two packed ASCII characters from encode |

## Verification
Decode is swept across all 256 byte values, so the digit range, both letter ranges and every neighbouring non-digit (such as 0x2F, 0x3A, 0x40, 0x47, 0x60, 0x67) are told apart, with each value checked against a bench table built from character strings. Encode is likewise swept across all 256 bytes, which separates the two nibble positions in the packed word and shows that values 10 to 15 come out uppercase. Idle cycles with a changing byte and mode on the inputs show that nothing unaccepted reaches the outputs, and alternating modes shows the unused outputs are cleared.

// File: rtl/hexc_pkg.sv
package hexc_pkg;

  localparam int CHAR_W = 8;
  localparam int NIB_W  = 4;
  localparam int NCHARS = CHAR_W / NIB_W;
  localparam int WORD_W = NCHARS * CHAR_W;

  localparam logic [CHAR_W-1:0] CH_DIG_LO = 8'h30;
  localparam logic [CHAR_W-1:0] CH_DIG_HI = 8'h39;
  localparam logic [CHAR_W-1:0] CH_UPR_LO = 8'h41;
  localparam logic [CHAR_W-1:0] CH_UPR_HI = 8'h46;
  localparam logic [CHAR_W-1:0] CH_LWR_LO = 8'h61;
  localparam logic [CHAR_W-1:0] CH_LWR_HI = 8'h66;
  localparam logic [CHAR_W-1:0] CASE_BIT  = 8'h20;

  typedef enum logic {
    MODE_DEC = 1'b0,
    MODE_ENC = 1'b1
  } codec_mode_e;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic             err;
  } dec_res_t;

  function automatic logic in_span(input logic [CHAR_W-1:0] c,
                                   input logic [CHAR_W-1:0] lo,
                                   input logic [CHAR_W-1:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction

  function automatic dec_res_t char_to_nib(input logic [CHAR_W-1:0] c);
    dec_res_t r;
    logic [CHAR_W-1:0] off;
    r.nib = '0;
    r.err = 1'b0;
    off   = '0;
    if (in_span(c, CH_DIG_LO, CH_DIG_HI)) begin
      off = c - CH_DIG_LO;
    end else if (in_span(c, CH_UPR_LO, CH_UPR_HI)) begin
      off = c - CH_UPR_LO + 8'd10;
    end else if (in_span(c, CH_LWR_LO, CH_LWR_HI)) begin
      off = c - CH_LWR_LO + 8'd10;
    end else begin
      r.err = 1'b1;
    end
    r.nib = off[NIB_W-1:0];
    return r;
  endfunction

  function automatic logic [CHAR_W-1:0] nib_to_char(input logic [NIB_W-1:0] n);
    logic [CHAR_W-1:0] wide;
    wide = {{(CHAR_W-NIB_W){1'b0}}, n};
    if (n < NIB_W'(10)) return CH_DIG_LO + wide;
    return CH_UPR_LO + wide - 8'd10;
  endfunction

endpackage

// File: rtl/hexc_decoder.sv
module hexc_decoder
  import hexc_pkg::*;
(
  input  logic [CHAR_W-1:0] ch,
  output logic [NIB_W-1:0]  nib,
  output logic              err
);

  dec_res_t res;
  logic     is_upper;

  always_comb begin
    res      = char_to_nib(ch);
    nib      = res.nib;
    err      = res.err;
    is_upper = in_span(ch, CH_UPR_LO, CH_UPR_HI);
  end

  // R4: an uppercase letter and its lowercase twin decode to the same value
  always_comb begin
    if (!$isunknown(ch) && is_upper) begin
      a_r4_case_fold: assert (char_to_nib(ch | CASE_BIT) == res);
    end
  end

  // R5: an error never comes with a nonzero value
  always_comb begin
    if (!$isunknown(ch)) begin
      a_r5_err_zero: assert (!err || nib == '0);
    end
  end

endmodule

// File: rtl/hexc_encoder.sv
module hexc_encoder
  import hexc_pkg::*;
(
  input  logic [CHAR_W-1:0] val,
  output logic [WORD_W-1:0] word
);

  for (genvar g = 0; g < NCHARS; g++) begin : g_char
    logic [NIB_W-1:0]  nib_in;
    logic [CHAR_W-1:0] ch_out;

    assign nib_in = val[g*NIB_W +: NIB_W];
    assign ch_out = nib_to_char(nib_in);
    assign word[g*CHAR_W +: CHAR_W] = ch_out;

    // R6: every produced character is a digit or an uppercase letter
    always_comb begin
      if (!$isunknown(nib_in)) begin
        a_r6_upper_only: assert (in_span(ch_out, CH_DIG_LO, CH_DIG_HI) ||
                                 in_span(ch_out, CH_UPR_LO, CH_UPR_HI));
      end
    end
  end

endmodule

// File: rtl/hexc_stage.sv
module hexc_stage
  import hexc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              mode,
  input  logic [NIB_W-1:0]  dec_nib,
  input  logic              dec_err,
  input  logic [WORD_W-1:0] enc_word,
  output logic              rdy,
  output logic              vld,
  output logic              mode_q,
  output logic [NIB_W-1:0]  nib_q,
  output logic              err_q,
  output logic [WORD_W-1:0] word_q
);

  logic is_enc;
  assign is_enc = (codec_mode_e'(mode) == MODE_ENC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      vld <= 1'b0;
    end else begin
      rdy <= 1'b1;
      vld <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      nib_q  <= '0;
      err_q  <= 1'b0;
      word_q <= '0;
    end else if (accept) begin
      mode_q <= mode;
      nib_q  <= is_enc ? '0 : dec_nib;
      err_q  <= is_enc ? 1'b0 : dec_err;
      word_q <= is_enc ? enc_word : '0;
    end
  end

  // R8: the strobe follows an accepted input by exactly one cycle
  a_r8_strobe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> vld);
  a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !vld);

  // R9: the outputs of the unused direction are cleared
  a_r9_enc_clears_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode_q) |-> (!err_q && nib_q == '0));
  a_r9_dec_clears_word: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !mode_q) |-> (word_q == '0));

  // R10: results hold while nothing is accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(word_q) && $stable(nib_q) && $stable(err_q)));

endmodule

// File: rtl/hex_char_codec.sv
module hex_char_codec
  import hexc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_mode,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  output logic [3:0]  out_nibble,
  output logic        out_err,
  output logic [15:0] out_word
);

  logic              accept;
  logic              ready_q;
  logic              mode_q;
  logic [NIB_W-1:0]  dec_nib;
  logic              dec_err;
  logic [WORD_W-1:0] enc_word;

  assign accept   = in_valid && ready_q;
  assign in_ready = ready_q;

  hexc_decoder u_dec (
    .ch  (in_byte),
    .nib (dec_nib),
    .err (dec_err)
  );

  hexc_encoder u_enc (
    .val  (in_byte),
    .word (enc_word)
  );

  hexc_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .mode     (in_mode),
    .dec_nib  (dec_nib),
    .dec_err  (dec_err),
    .enc_word (enc_word),
    .rdy      (ready_q),
    .vld      (out_valid),
    .mode_q   (mode_q),
    .nib_q    (out_nibble),
    .err_q    (out_err),
    .word_q   (out_word)
  );

  // R10: once ready, the block stays ready
  a_r10_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R5: an erroring decode result carries a zero value
  a_r5_err_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_nibble == 4'h0 && !mode_q));

endmodule

// File: tb/hex_char_codec_bench.sv
module hex_char_codec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic [3:0]  out_nibble;
  logic        out_err;
  logic [15:0] out_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  hex_char_codec u_hex_char_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_byte(in_byte), .out_valid(out_valid),
    .out_nibble(out_nibble), .out_err(out_err), .out_word(out_word)
  );

  string upper_set = "0123456789ABCDEF";
  string lower_set = "0123456789abcdef";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model: search the character tables
  task automatic model_dec(input logic [7:0] b, output logic [3:0] v, output logic e);
    v = 4'h0;
    e = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (upper_set[i] == b || lower_set[i] == b) begin
        v = 4'(i);
        e = 1'b0;
      end
    end
  endtask

  function automatic logic [15:0] model_enc(input logic [7:0] b);
    return {upper_set[b[7:4]], upper_set[b[3:0]]};
  endfunction

  // present one byte for one cycle; returns at the negedge after the capture edge
  task automatic apply(input logic m, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = m;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    #12;
    chk("R1 in_ready", in_ready, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_nibble", out_nibble, 0);
    chk("R1 out_err", out_err, 0);
    chk("R1 out_word", out_word, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", in_ready, 1);
  endtask

  task automatic t_decode_sweep;
    logic [3:0] v;
    logic e;
    string tag;
    for (int b = 0; b < 256; b++) begin
      apply(1'b0, 8'(b));
      model_dec(8'(b), v, e);
      if (b >= 8'h30 && b <= 8'h39) tag = "R2";
      else if (b >= 8'h41 && b <= 8'h46) tag = "R3";
      else if (b >= 8'h61 && b <= 8'h66) tag = "R4";
      else tag = "R5";
      chk({tag, " dec nibble"}, out_nibble, v);
      chk({tag, " dec err"}, out_err, e);
      chk("R8 dec out_valid", out_valid, 1);
      chk("R9 dec word zero", out_word, 0);
    end
  endtask

  task automatic t_encode_sweep;
    for (int b = 0; b < 256; b++) begin
      apply(1'b1, 8'(b));
      chk("R6 enc low char", out_word[7:0], model_enc(8'(b)) & 16'h00ff);
      chk("R7 enc high char", out_word[15:8], model_enc(8'(b)) >> 8);
      chk("R8 enc out_valid", out_valid, 1);
      chk("R9 enc nibble zero", out_nibble, 0);
      chk("R9 enc err zero", out_err, 0);
    end
  endtask

  task automatic t_hold_idle;
    apply(1'b0, "B");
    chk("R3 dec B", out_nibble, 11);
    for (int k = 0; k < 3; k++) begin
      in_byte = 8'(k * 37 + 3);
      in_mode = k[0];
      @(negedge clk);
      chk("R8 no strobe idle", out_valid, 0);
      chk("R10 hold nibble", out_nibble, 11);
      chk("R10 hold err", out_err, 0);
      chk("R10 hold word", out_word, 0);
    end
  endtask

  task automatic t_mode_cross;
    apply(1'b1, 8'h5c);
    chk("R7 enc 5C", out_word, 16'h3543);
    apply(1'b0, "f");
    chk("R4 dec f", out_nibble, 15);
    chk("R9 word cleared", out_word, 0);
    apply(1'b0, "G");
    chk("R5 dec G err", out_err, 1);
    chk("R5 dec G nibble", out_nibble, 0);
    apply(1'b1, 8'hae);
    chk("R6 enc AE upper", out_word, 16'h4145);
    chk("R9 err cleared", out_err, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = 1'b0;
    in_byte  = "7";
    @(negedge clk);
    chk("R8 b2b first", out_nibble, 7);
    in_byte = "c";
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 b2b second", out_nibble, 12);
    chk("R8 b2b valid", out_valid, 1);
    @(negedge clk);
    chk("R8 b2b idle", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_decode_sweep();
    t_encode_sweep();
    t_hold_idle();
    t_mode_cross();
    t_back_to_back();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule